// File: doc/BRIEF.md
# Infrared Pulse Run-Length Sampler

This block watches the single-bit output of an infrared receiver and turns it into a stream of run-length bytes for a receive FIFO. It samples the line at a fixed fraction of the base clock: one sample every `CLK_DIV` base cycles, which with a divider of 64 on an 8 MHz clock gives an 8 µs step. Each byte holds the level of a run in its top bit and the run's length in samples, minus one, in its lower seven bits. The input can be inverted before sampling, so receivers with either idle polarity can be used.

Two programmable thresholds shape the output. The noise threshold sets the shortest run that is accepted. Anything shorter is absorbed into the level around it. The idle threshold sets how long a space may last before the current packet is closed. When that happens, the pending space is written as a last byte and a one-cycle packet-end pulse follows. Sampling happens only while both the global enable and the receive enable are high.

Top module: `ir_run_sampler`

## Requirements
- R1: While `glb_en` and `rx_en` are both high, the line is sampled once every `CLK_DIV` clock cycles, so a level held for k·`CLK_DIV` cycles counts as exactly k samples. While either enable is low, nothing is sampled.
- R2: Each byte written on `fifo_data` with `fifo_wr` high has bit 7 = 1 for a pulse and 0 for a space. Bits 6:0 hold the run length in samples minus one. A byte for a run is written when the filtered level changes.
- R3: When `pol_inv` is 1, the pin is inverted before sampling. Pin high is then a space and pin low is a pulse. When `pol_inv` is 0, pin high is a pulse.
- R4: A change of level counts only once the new level has lasted `noise_thr` consecutive samples. Shorter runs merge into the surrounding level. `noise_thr` values 0 and 1 both disable filtering.
- R5: When a space run inside a packet reaches `idle_thr` samples, the space byte is written and `pkt_end` pulses for one cycle on the cycle after that write. Values of `idle_thr` below 2 act as 2.
- R6: When a run continues beyond 128 samples, the byte {level, 0x7F} is written and counting restarts in a new byte of the same level. A final space byte written at idle saturates at 0x7F.
- R7: Outside a packet, space samples are ignored. The first byte of each packet describes a pulse.
- R8: Dropping either enable discards any unfinished run and returns to the idle, out-of-packet state without writing anything.
- R9: During and right after reset, `fifo_wr`, `fifo_data` and `pkt_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_pin | input | 1 | Raw, asynchronous receiver line |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| pol_inv | input | 1 | Invert the line before sampling |
| noise_thr | input | NOISE_W | Minimum accepted run, in samples |
| idle_thr | input | IDLE_W | Space length that closes a packet, in samples |
| fifo_wr | output | 1 | Byte write strobe |
| fifo_data | output | LEN_W+1 | Run-length byte: level in the top bit, length minus one below |
| pkt_end | output | 1 | One-cycle packet-end pulse |

## Verification
The bench builds the block with `CLK_DIV` = 4 and leaves the field widths at their defaults. This makes each sample four cycles long, so runs of several hundred samples stay cheap. As a result, the 128-sample split, the saturation of the idle flush at 0x7F, and idle thresholds near 200 can all be reached within a short run. Expected bytes come from a per-sample model of the filter and the packetiser, fed with the same segment lists the driver applies to the pin.

// File: rtl/ir_run_pkg.sv
package ir_run_pkg;
  // Pack a run into the output byte: level on top, length minus one below.
  function automatic logic [7:0] pack_run(input logic lvl, input logic [6:0] len_m1);
    return {lvl, len_m1};
  endfunction

  // Idle threshold with the floor of two samples applied.
  function automatic logic [8:0] eff_idle(input logic [7:0] thr);
    return (thr < 8'd2) ? 9'd2 : {1'b0, thr};
  endfunction

  // A filtered level change is accepted when the opposing streak reaches thr.
  function automatic logic streak_done(input logic [5:0] streak, input logic [5:0] thr);
    return ({1'b0, streak} + 7'd1) >= {1'b0, thr};
  endfunction
endpackage

// File: rtl/ir_line_sync.sv
module ir_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic inv,
  output logic lvl
);
  logic meta_q, stab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= pin;
      stab_q <= meta_q;
    end
  end

  assign lvl = stab_q ^ inv;
endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int CLK_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign tick = run && (phase_q == LAST);

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/ir_noise_filter.sv
module ir_noise_filter #(
  parameter int NOISE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               tick,
  input  logic               smp,
  input  logic [NOISE_W-1:0] thr,
  output logic               lvl_next
);
  import ir_run_pkg::*;

  logic               lvl_q;
  logic [NOISE_W-1:0] streak_q;
  logic               accept;

  assign accept   = (smp != lvl_q) && streak_done(streak_q, thr);
  assign lvl_next = accept ? smp : lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lvl_q    <= 1'b0;
      streak_q <= '0;
    end else if (tick) begin
      lvl_q <= lvl_next;
      if (smp == lvl_q || accept) streak_q <= '0;
      else streak_q <= streak_q + 1'b1;
    end
  end

  // R4
  filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lvl_q) || $past(clr));
endmodule

// File: rtl/ir_run_encoder.sv
module ir_run_encoder #(
  parameter int LEN_W  = 7,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              flv,
  input  logic [IDLE_W-1:0] idle_thr,
  output logic              wr,
  output logic [LEN_W:0]    data,
  output logic              pkt_end
);
  import ir_run_pkg::*;

  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic              active_q, lvl_q, flush_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [IDLE_W:0]   sp_q;
  logic              wr_q, end_q;
  logic [LEN_W:0]    data_q;
  logic              idle_hit;

  assign idle_hit = !lvl_q && ((sp_q + 1'b1) >= eff_idle(idle_thr));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      active_q <= 1'b0;
      lvl_q    <= 1'b0;
      cnt_q    <= '0;
      sp_q     <= '0;
      flush_q  <= 1'b0;
      wr_q     <= 1'b0;
      end_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      wr_q    <= 1'b0;
      flush_q <= 1'b0;
      end_q   <= flush_q;
      if (tick) begin
        if (!active_q) begin
          if (flv) begin
            active_q <= 1'b1;
            lvl_q    <= 1'b1;
            cnt_q    <= '0;
            sp_q     <= '0;
          end
        end else if (flv != lvl_q) begin
          wr_q   <= 1'b1;
          data_q <= pack_run(lvl_q, cnt_q);
          lvl_q  <= flv;
          cnt_q  <= '0;
          sp_q   <= flv ? '0 : (IDLE_W+1)'(1);
        end else if (idle_hit) begin
          wr_q     <= 1'b1;
          data_q   <= pack_run(1'b0, (cnt_q == LEN_MAX) ? LEN_MAX : cnt_q + 1'b1);
          flush_q  <= 1'b1;
          active_q <= 1'b0;
          cnt_q    <= '0;
          sp_q     <= '0;
        end else begin
          if (!lvl_q) sp_q <= sp_q + 1'b1;
          if (cnt_q == LEN_MAX) begin
            wr_q   <= 1'b1;
            data_q <= pack_run(lvl_q, LEN_MAX);
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign wr      = wr_q;
  assign data    = data_q;
  assign pkt_end = end_q;

  // R5
  pkt_end_after_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> $past(wr_q && !data_q[LEN_W]));
  // R5
  end_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> !wr_q);
  // R8
  write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(!clr && tick));
  // R7
  open_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> lvl_q);
endmodule

// File: rtl/ir_run_sampler.sv
module ir_run_sampler #(
  parameter int CLK_DIV = 64,
  parameter int NOISE_W = 6,
  parameter int IDLE_W  = 8,
  parameter int LEN_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ir_pin,
  input  logic               glb_en,
  input  logic               rx_en,
  input  logic               pol_inv,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  output logic               fifo_wr,
  output logic [LEN_W:0]     fifo_data,
  output logic               pkt_end
);
  logic run, clr, tick, smp, flv;

  assign run = glb_en && rx_en;
  assign clr = !run;

  ir_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ir_pin), .inv(pol_inv), .lvl(smp)
  );

  ir_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  ir_noise_filter #(.NOISE_W(NOISE_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .smp(smp),
    .thr(noise_thr), .lvl_next(flv)
  );

  ir_run_encoder #(.LEN_W(LEN_W), .IDLE_W(IDLE_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .flv(flv),
    .idle_thr(idle_thr), .wr(fifo_wr), .data(fifo_data), .pkt_end(pkt_end)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !fifo_wr && !pkt_end);
endmodule

// File: tb/ir_run_sampler_tb.sv
module ir_run_sampler_tb_top;
  localparam int DIV = 4;
  localparam int END_MARK = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_pin = 1'b0, glb_en = 1'b0, rx_en = 1'b0, pol_inv = 1'b0;
  logic [5:0] noise_thr = 6'd1;
  logic [7:0] idle_thr = 8'd20;
  logic       fifo_wr, pkt_end;
  logic [7:0] fifo_data;

  int n_chk = 0, n_fail = 0, wr_seen = 0;
  int exp_q[$];
  string tag_q[$];
  int seg_lv[$], seg_ln[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  ir_run_sampler #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .ir_pin(ir_pin), .glb_en(glb_en), .rx_en(rx_en),
    .pol_inv(pol_inv), .noise_thr(noise_thr), .idle_thr(idle_thr),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .pkt_end(pkt_end)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every byte write and every packet end.
  always @(negedge clk) begin
    if (rst_n && fifo_wr) begin
      wr_seen++;
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected write", int'(fifo_data), -1);
      else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(int'(fifo_data) == e, t, int'(fifo_data), e);
      end
    end
    if (rst_n && pkt_end) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected packet end", 1, 0);
      else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(e == END_MARK, {t, " packet end"}, END_MARK, e);
      end
    end
  end

  function automatic void expect_item(input string tag, input int v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endfunction

  // Sample-level model of the requirements (R2, R4, R5, R6, R7).
  task automatic model(input string tag, input int nthr, input int ithr, input int smps[$]);
    int filt = 0, streak = 0, len = 0, spc = 0, cur = 0;
    bit open = 1'b0;
    int lim = (ithr < 2) ? 2 : ithr;
    foreach (smps[i]) begin
      if (smps[i] == filt) streak = 0;
      else if (streak + 1 >= nthr) begin filt = smps[i]; streak = 0; end
      else streak++;
      if (!open) begin
        if (filt == 1) begin open = 1'b1; cur = 1; len = 1; end
      end else if (filt != cur) begin
        expect_item(tag, cur * 128 + (len - 1));
        cur = filt; len = 1; spc = (filt == 0) ? 1 : 0;
      end else begin
        len++;
        if (cur == 0) spc++;
        if (cur == 0 && spc >= lim) begin
          expect_item(tag, (len - 1 > 127) ? 127 : len - 1);
          expect_item(tag, END_MARK);
          open = 1'b0;
        end else if (len == 129) begin
          expect_item(tag, cur * 128 + 127);
          len = 1;
        end
      end
    end
  endtask

  task automatic run_case(input string tag, input bit inv, input int nthr, input int ithr);
    int smps[$];
    int lim = (ithr < 2) ? 2 : ithr;
    int trail = lim + nthr + 3;
    foreach (seg_lv[i]) for (int k = 0; k < seg_ln[i]; k++) smps.push_back(seg_lv[i]);
    for (int k = 0; k < trail; k++) smps.push_back(0);
    model(tag, nthr, ithr, smps);
    @(negedge clk);
    pol_inv = inv; noise_thr = 6'(nthr); idle_thr = 8'(ithr); ir_pin = inv;
    repeat (4) @(negedge clk);
    glb_en = 1'b1; rx_en = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    foreach (seg_lv[i]) begin
      ir_pin = 1'(seg_lv[i]) ^ inv;
      repeat (seg_ln[i] * DIV) @(negedge clk);
    end
    ir_pin = inv;
    repeat ((trail + 2) * DIV) @(negedge clk);
    glb_en = 1'b0; rx_en = 1'b0;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, {tag, " all expected items seen"}, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
    seg_lv.delete(); seg_ln.delete();
  endtask

  task automatic seg(input int lv, input int ln);
    seg_lv.push_back(lv);
    seg_ln.push_back(ln);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!fifo_wr && !pkt_end && fifo_data == 8'h00, "R9 reset outputs",
          {fifo_wr, pkt_end, fifo_data}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!fifo_wr && !pkt_end, "R9 after reset", {fifo_wr, pkt_end}, 0);

    // R1 R2 basic byte format and sample counting
    seg(1, 5); seg(0, 3); seg(1, 2);
    run_case("R1 R2 basic runs", 1'b0, 1, 20);
    // R3 inverted line
    seg(1, 5); seg(0, 3); seg(1, 2); seg(0, 4); seg(1, 7);
    run_case("R3 inverted input", 1'b1, 1, 20);
    // R4 noise merge
    seg(1, 10); seg(0, 2); seg(1, 10); seg(0, 4); seg(1, 6); seg(0, 1); seg(1, 3);
    run_case("R4 noise threshold 3", 1'b0, 3, 20);
    // R4 threshold zero disables filtering
    seg(1, 1); seg(0, 1); seg(1, 2);
    run_case("R4 noise threshold 0", 1'b0, 0, 20);
    // R6 long runs split
    seg(1, 300); seg(0, 5); seg(1, 128); seg(0, 2); seg(1, 129);
    run_case("R6 long run split", 1'b0, 1, 20);
    // R6 saturated idle flush
    seg(1, 4);
    run_case("R6 idle flush saturates", 1'b0, 1, 129);
    // R6 long space inside a packet
    seg(1, 3); seg(0, 150); seg(1, 2);
    run_case("R6 long space split", 1'b0, 2, 200);
    // R5 idle threshold floor
    seg(1, 3);
    run_case("R5 idle threshold 0", 1'b0, 1, 0);
    // R7 short leading pulse filtered, first byte is a pulse
    seg(1, 2); seg(0, 5); seg(1, 4);
    run_case("R7 first run pulse", 1'b0, 3, 20);

    // R8 one enable alone: no sampling
    wr_seen = 0;
    @(negedge clk); pol_inv = 1'b0; idle_thr = 8'd20; noise_thr = 6'd1;
    glb_en = 1'b1; rx_en = 1'b0;
    repeat (4) begin ir_pin = 1'b1; repeat (5 * DIV) @(negedge clk); ir_pin = 1'b0; repeat (5 * DIV) @(negedge clk); end
    glb_en = 1'b0; rx_en = 1'b1;
    repeat (2) begin ir_pin = 1'b1; repeat (5 * DIV) @(negedge clk); ir_pin = 1'b0; repeat (5 * DIV) @(negedge clk); end
    check(wr_seen == 0, "R8 single enable gives no writes", wr_seen, 0);
    // R8 disable mid-packet discards the run
    rx_en = 1'b0; glb_en = 1'b0;
    repeat (4) @(negedge clk);
    glb_en = 1'b1; rx_en = 1'b1;
    ir_pin = 1'b1; repeat (6 * DIV) @(negedge clk);
    glb_en = 1'b0;
    ir_pin = 1'b0; repeat (4 * DIV) @(negedge clk);
    glb_en = 1'b1;
    repeat (40 * DIV) @(negedge clk);
    check(wr_seen == 0 && !pkt_end, "R8 disable discards pending run", wr_seen, 0);
    glb_en = 1'b0; rx_en = 1'b0;
    repeat (4) @(negedge clk);
    // R8 after the discard, a fresh packet starts cleanly
    seg(1, 6); seg(0, 3); seg(1, 2);
    run_case("R8 restart after discard", 1'b0, 1, 20);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule